// File: doc/BRIEF.md
# Quadword write burst planner

This block sits between a buffered target-write path and a push/pull DRAM command port. It takes one write command, made of a start byte address, a byte count and per-quadword byte enables. It turns that command into a sequence of memory requests. Each request carries an 8-byte-aligned address, a length in quadwords and a flag that marks a partial (byte-masked) write. The data and the buffer itself stay outside the block. The block only decides how the write is cut up and when each piece may go.

The byte enables are read through a lookup port. The block presents a quadword index on `be_qidx` and expects the buffer to return that quadword's 8-bit mask on `be_mask` in the same cycle. The buffer also reports, on `fill_qw`, how many quadwords of the current write it holds. That count runs from the write's first aligned quadword and must not decrease while a write is in progress. Commands use a valid/ready handshake. `cmd_ready` is high only when the block is idle, and a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. Requests also use a valid/ready handshake. Once `req_valid` is high it stays high, with address, length and flag unchanged, until the cycle where `req_ready` is high. The consumer may hold `req_ready` low for any number of cycles. A one-cycle `done` pulse closes every command.

Top module: `qw_burst_planner`

## Requirements
- R1: Every request address has its three low bits equal to zero. This address is the aligned quadword that contains the first byte the request covers.
- R2: No request crosses a 64-byte boundary: (address bits [5:3]) + length never exceeds 8. A run of full quadwords that reaches the last quadword of a 64-byte segment is closed there, and the next quadword starts a new request.
- R3: A quadword is partial when its effective mask is not 8'hFF. The effective mask is `be_mask` ANDed with the bytes the command covers in that quadword. Bit b stands for byte b of the quadword. The first quadword covers bytes from address[2:0] upward, and the last quadword covers bytes up to (address+count-1)[2:0]. A partial quadword is issued alone, with length 1 and `req_partial`=1.
- R4: Consecutive full quadwords in one segment are merged into a single request with `req_partial`=0. A partial quadword ends the run in front of it.
- R5: Requests come out in ascending address order and cover each quadword of the command exactly once.
- R6: A request is valid only while `fill_qw` >= (request quadword offset from the command's first aligned quadword) + length.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid on the next cycle with the same address, length and flag.
- R8: `done` is high for exactly one cycle. That cycle is the one after the handshake of the last request. For a zero-byte command, it is the cycle after the command is taken, and no request is made.
- R9: `cmd_ready` is low from the cycle after a command is taken through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Block idle; command taken when both high |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_bytes | input | LEN_W | Byte count (0 allowed) |
| be_qidx | output | QI_W | Quadword index whose mask is looked up |
| be_mask | input | 8 | Byte-enable mask of quadword `be_qidx` |
| fill_qw | input | QI_W | Quadwords of this write present in the buffer |
| req_valid | output | 1 | Memory request offered |
| req_ready | input | 1 | Memory request accepted |
| req_addr | output | ADDR_W | Aligned request address |
| req_len | output | RL_W | Request length in quadwords (1..SEG_QW) |
| req_partial | output | 1 | Request is a masked single-quadword write |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The bench targets writes that start and end inside a quadword, runs that touch the last quadword of a segment, and byte-enable holes in the middle of a segment. It also covers zero-byte commands and a buffer that fills slowly or stalls. A planner that gets segment ends wrong issues a nine-quadword burst, or splits at the wrong quadword. A planner that ignores the masks turns a hole into part of a full burst. A planner that drops the pending run on a hole loses quadwords. A planner that ignores `fill_qw` raises `req_valid` before the data is there. Random back-pressure on `req_ready` exposes any request that changes or disappears while it waits. Timing checks on `done` catch a missing pulse, a late pulse or a doubled pulse.

// File: rtl/qw_burst_pkg.sv
package qw_burst_pkg;
  typedef enum logic [1:0] {
    PL_IDLE  = 2'd0,
    PL_SCAN  = 2'd1,
    PL_ISSUE = 2'd2,
    PL_DONE  = 2'd3
  } plan_state_e;
endpackage

// File: rtl/qw_span_calc.sv
// Derives quadword geometry of a command: first aligned quadword,
// quadword count and the byte offsets at both ends.
module qw_span_calc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int QI_W   = LEN_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  bytes,
  output logic [ADDR_W-4:0] base_qw,
  output logic [QI_W-1:0]   nqw,
  output logic [2:0]        head_off,
  output logic [2:0]        tail_off
);
  localparam int SUM_W = LEN_W + 2;
  logic [SUM_W-1:0] span_end;
  logic [SUM_W-1:0] last_byte;

  always_comb begin
    base_qw   = addr[ADDR_W-1:3];
    head_off  = addr[2:0];
    span_end  = SUM_W'(addr[2:0]) + SUM_W'(bytes) + SUM_W'(7);
    last_byte = SUM_W'(addr[2:0]) + SUM_W'(bytes) - SUM_W'(1);
    nqw       = QI_W'(span_end >> 3);
    tail_off  = last_byte[2:0];
  end
endmodule

// File: rtl/qw_edge_mask.sv
// Combines the byte range of the command with the buffer byte enables
// for the quadword under inspection and reports whether it is full.
module qw_edge_mask #(
  parameter int QI_W = 10
) (
  input  logic [QI_W-1:0] cur,
  input  logic [QI_W-1:0] nqw,
  input  logic [2:0]      head_off,
  input  logic [2:0]      tail_off,
  input  logic [7:0]      be_in,
  output logic            is_last,
  output logic            is_full
);
  logic [2:0] lo;
  logic [2:0] hi;
  logic [7:0] range_m;

  always_comb begin
    is_last = (cur == nqw - QI_W'(1));
    lo      = (cur == '0) ? head_off : 3'd0;
    hi      = is_last ? tail_off : 3'd7;
  end

  for (genvar b = 0; b < 8; b++) begin : g_byte
    assign range_m[b] = (3'(b) >= lo) && (3'(b) <= hi);
  end

  assign is_full = ((range_m & be_in) == 8'hFF);
endmodule

// File: rtl/qw_run_step.sv
// One scan step: extends, closes or breaks the current run of full
// quadwords and tells whether a request is ready to be issued.
module qw_run_step #(
  parameter int QI_W = 10,
  parameter int RL_W = 4
) (
  input  logic [QI_W-1:0] cur,
  input  logic [QI_W-1:0] run_start,
  input  logic [RL_W-1:0] run_len,
  input  logic            is_full,
  input  logic            is_last,
  input  logic            seg_last,
  output logic            emit,
  output logic [QI_W-1:0] emit_start,
  output logic [RL_W-1:0] emit_len,
  output logic            emit_partial,
  output logic            advance,
  output logic [QI_W-1:0] nxt_start,
  output logic [RL_W-1:0] nxt_len
);
  logic [QI_W-1:0] t_start;
  logic [RL_W-1:0] t_len;

  always_comb begin
    t_start      = (run_len == '0) ? cur : run_start;
    t_len        = run_len + RL_W'(1);
    emit         = 1'b0;
    emit_start   = cur;
    emit_len     = RL_W'(1);
    emit_partial = 1'b0;
    advance      = 1'b1;
    nxt_start    = run_start;
    nxt_len      = '0;
    if (!is_full) begin
      emit = 1'b1;
      if (run_len != '0) begin
        emit_start = run_start;
        emit_len   = run_len;
        advance    = 1'b0;
      end else begin
        emit_partial = 1'b1;
      end
    end else if (seg_last || is_last) begin
      emit       = 1'b1;
      emit_start = t_start;
      emit_len   = t_len;
    end else begin
      nxt_start = t_start;
      nxt_len   = t_len;
    end
  end
endmodule

// File: rtl/qw_burst_planner.sv
module qw_burst_planner
  import qw_burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int SEG_QW = 8,
  parameter int QI_W   = LEN_W - 2,
  parameter int RL_W   = $clog2(SEG_QW) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_bytes,
  output logic [QI_W-1:0]   be_qidx,
  input  logic [7:0]        be_mask,
  input  logic [QI_W-1:0]   fill_qw,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [RL_W-1:0]   req_len,
  output logic              req_partial,
  output logic              done
);
  localparam int SEG_LOG = $clog2(SEG_QW);
  localparam int QA_W    = ADDR_W - 3;

  plan_state_e state;

  logic [QA_W-1:0] base_r;
  logic [QI_W-1:0] nqw_r;
  logic [2:0]      head_r, tail_r;
  logic [QI_W-1:0] cur;
  logic [QI_W-1:0] run_start;
  logic [RL_W-1:0] run_len;
  logic [QI_W-1:0] rq_start;
  logic [RL_W-1:0] rq_len;
  logic            rq_partial;

  logic [QA_W-1:0] c_base;
  logic [QI_W-1:0] c_nqw;
  logic [2:0]      c_head, c_tail;

  qw_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .QI_W(QI_W)) u_span (
    .addr(cmd_addr), .bytes(cmd_bytes), .base_qw(c_base),
    .nqw(c_nqw), .head_off(c_head), .tail_off(c_tail)
  );

  logic is_last, is_full, seg_last;
  logic [QA_W-1:0] cur_abs;

  qw_edge_mask #(.QI_W(QI_W)) u_mask (
    .cur(cur), .nqw(nqw_r), .head_off(head_r), .tail_off(tail_r),
    .be_in(be_mask), .is_last(is_last), .is_full(is_full)
  );

  always_comb begin
    cur_abs  = base_r + QA_W'(cur);
    seg_last = &cur_abs[SEG_LOG-1:0];
  end

  logic            emit, emit_partial, advance;
  logic [QI_W-1:0] emit_start, nxt_start;
  logic [RL_W-1:0] emit_len, nxt_len;

  qw_run_step #(.QI_W(QI_W), .RL_W(RL_W)) u_step (
    .cur(cur), .run_start(run_start), .run_len(run_len),
    .is_full(is_full), .is_last(is_last), .seg_last(seg_last),
    .emit(emit), .emit_start(emit_start), .emit_len(emit_len),
    .emit_partial(emit_partial), .advance(advance),
    .nxt_start(nxt_start), .nxt_len(nxt_len)
  );

  logic [QI_W:0] rq_end;
  logic          data_ok;

  always_comb begin
    rq_end      = (QI_W+1)'(rq_start) + (QI_W+1)'(rq_len);
    data_ok     = ((QI_W+1)'(fill_qw) >= rq_end);
    cmd_ready   = (state == PL_IDLE);
    done        = (state == PL_DONE);
    req_valid   = (state == PL_ISSUE) && data_ok;
    req_addr    = {base_r + QA_W'(rq_start), 3'b000};
    req_len     = rq_len;
    req_partial = rq_partial;
    be_qidx     = cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= PL_IDLE;
      base_r     <= '0;
      nqw_r      <= '0;
      head_r     <= '0;
      tail_r     <= '0;
      cur        <= '0;
      run_start  <= '0;
      run_len    <= '0;
      rq_start   <= '0;
      rq_len     <= '0;
      rq_partial <= 1'b0;
    end else begin
      unique case (state)
        PL_IDLE: begin
          if (cmd_valid) begin
            base_r  <= c_base;
            nqw_r   <= c_nqw;
            head_r  <= c_head;
            tail_r  <= c_tail;
            cur     <= '0;
            run_len <= '0;
            state   <= (cmd_bytes == '0) ? PL_DONE : PL_SCAN;
          end
        end
        PL_SCAN: begin
          if (advance) cur <= cur + QI_W'(1);
          run_start <= nxt_start;
          run_len   <= nxt_len;
          if (emit) begin
            rq_start   <= emit_start;
            rq_len     <= emit_len;
            rq_partial <= emit_partial;
            state      <= PL_ISSUE;
          end
        end
        PL_ISSUE: begin
          if (req_valid && req_ready)
            state <= (rq_end == (QI_W+1)'(nqw_r)) ? PL_DONE : PL_SCAN;
        end
        PL_DONE: state <= PL_IDLE;
        default: state <= PL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qw_burst_planner_chk.sv
module qw_burst_planner_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int SEG_QW = 8,
  parameter int QI_W   = LEN_W - 2,
  parameter int RL_W   = $clog2(SEG_QW) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_bytes,
  input logic [QI_W-1:0]   fill_qw,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [RL_W-1:0]   req_len,
  input logic              req_partial,
  input logic              done
);
  localparam int SEG_LOG = $clog2(SEG_QW);
  localparam int QA_W    = ADDR_W - 3;

  logic [QA_W-1:0] base_l;
  logic [QA_W-1:0] next_abs;
  logic            busy;
  logic [QA_W-1:0] req_qw;
  logic [QA_W:0]   rel_end;
  logic [RL_W:0]   seg_end;

  always_comb begin
    req_qw  = req_addr[ADDR_W-1:3];
    rel_end = (QA_W+1)'(req_qw - base_l) + (QA_W+1)'(req_len);
    seg_end = (RL_W+1)'(req_addr[3 +: SEG_LOG]) + (RL_W+1)'(req_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_l   <= '0;
      next_abs <= '0;
      busy     <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        base_l   <= cmd_addr[ADDR_W-1:3];
        next_abs <= cmd_addr[ADDR_W-1:3];
        busy     <= 1'b1;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (req_valid && req_ready) next_abs <= req_qw + QA_W'(req_len);
    end
  end

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[2:0] == 3'b000));
  a_r2_in_segment: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (seg_end <= (RL_W+1)'(SEG_QW)) && (req_len != '0));
  a_r3_partial_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_partial) |-> (req_len == RL_W'(1)));
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_qw == next_abs));
  a_r6_data_present: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((QA_W+1)'(fill_qw) >= rel_end));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr)
      && $stable(req_len) && $stable(req_partial));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

bind qw_burst_planner qw_burst_planner_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_QW(SEG_QW), .QI_W(QI_W), .RL_W(RL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .fill_qw(fill_qw),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .req_partial(req_partial), .done(done)
);

// File: tb/qw_burst_planner_test.sv
module qw_burst_planner_test;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int QI_W   = 10;
  localparam int RL_W   = 4;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  len;
    logic        part;
  } req_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [11:0] cmd_bytes = '0;
  logic [9:0]  be_qidx;
  logic [7:0]  be_mask;
  logic [9:0]  fill_qw = '0;
  logic req_valid, req_ready, req_partial, done;
  logic [31:0] req_addr;
  logic [3:0]  req_len;

  logic [7:0] be_tab [64];
  int fill_lim = 0;
  int fill_div = 1;
  int fill_tick = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int cycles = 0;
  req_t expq[$];

  always #10 clk = ~clk;

  assign be_mask = be_tab[be_qidx[5:0]];

  qw_burst_planner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_QW(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .be_qidx(be_qidx),
    .be_mask(be_mask), .fill_qw(fill_qw), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_partial(req_partial), .done(done)
  );

  // input generators, all driven on the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (done) begin
      fill_qw = '0;
      fill_tick = 0;
    end else if (int'(fill_qw) < fill_lim) begin
      if (fill_tick >= fill_div - 1) begin
        fill_qw = fill_qw + 10'd1;
        fill_tick = 0;
      end else fill_tick++;
    end
  end
  assign req_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];

  task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // monitor: samples 5 ns before each rising edge
  bit expect_done = 0;
  bit busy = 0;
  always begin
    @(negedge clk);
    #5;
    cycles++;
    if (rst_n) begin
      if (expect_done) begin
        checks++;
        if (done !== 1'b1) fail("R8", "done after last request", {63'b0, done}, 64'd1);
        expect_done = 0;
      end
      if (busy && cmd_ready) begin
        checks++;
        fail("R9", "cmd_ready while busy", 64'd1, 64'd0);
      end
      if (done) begin
        done_cnt++;
        busy = 0;
        checks++;
        if (expq.size() != 0) fail("R5", "done with requests missing", 64'(expq.size()), 64'd0);
      end
      if (cmd_valid && cmd_ready) begin
        busy = 1;
        if (cmd_bytes == '0) expect_done = 1;
      end
      if (req_valid) begin
        checks++;
        if (int'(fill_qw) < int'((req_addr >> 3) - (cmd_addr >> 3)) + int'(req_len))
          fail("R6", "request before data", 64'(fill_qw), 64'(((req_addr >> 3) - (cmd_addr >> 3)) + req_len));
      end
      if (req_valid && req_ready) begin
        checks++;
        if (expq.size() == 0) fail("R5", "unexpected request", 64'(req_addr), 64'd0);
        else begin
          req_t e;
          e = expq.pop_front();
          if (req_addr !== e.addr || req_len !== e.len || req_partial !== e.part)
            fail("R2/R3/R4", "request addr/len/partial",
                 {27'b0, req_addr, req_len, req_partial}, {27'b0, e.addr, e.len, e.part});
          if (expq.size() == 0) expect_done = 1;
        end
      end
    end
  end

  function automatic logic [7:0] rmask(input int lo, input int hi);
    logic [7:0] m = '0;
    for (int b = 0; b < 8; b++) if (b >= lo && b <= hi) m[b] = 1'b1;
    return m;
  endfunction

  task automatic push(input logic [31:0] a, input int s, input int l, input bit p);
    req_t r;
    r.addr = ((a >> 3) + s) << 3;
    r.len  = 4'(l);
    r.part = p;
    expq.push_back(r);
  endtask

  // expected requests from the requirements (R1..R5)
  task automatic plan(input logic [31:0] a, input int n);
    int off = int'(a[2:0]);
    int nq = (off + n + 7) / 8;
    int rs = 0;
    int rl = 0;
    if (n == 0) return;
    for (int i = 0; i < nq; i++) begin
      int lo = (i == 0) ? off : 0;
      int hi = (i == nq - 1) ? ((off + n - 1) % 8) : 7;
      bit full = ((be_tab[i] & rmask(lo, hi)) == 8'hFF);
      int absq = int'(a >> 3) + i;
      if (!full) begin
        if (rl > 0) push(a, rs, rl, 0);
        rl = 0;
        push(a, i, 1, 1);
      end else begin
        if (rl == 0) rs = i;
        rl++;
        if ((absq % 8) == 7 || i == nq - 1) begin
          push(a, rs, rl, 0);
          rl = 0;
        end
      end
    end
  endtask

  task automatic run(input logic [31:0] a, input int n, input int lim, input int div, input int mode);
    int start_cnt = done_cnt;
    int guard = 0;
    plan(a, n);
    @(negedge clk);
    fill_lim = lim;
    fill_div = div;
    rdy_mode = mode;
    cmd_addr = a;
    cmd_bytes = 12'(n);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (done_cnt == start_cnt && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) fail("R8", "no done", 64'd0, 64'd1);
    expq.delete();
    @(negedge clk);
  endtask

  task automatic be_all();
    for (int i = 0; i < 64; i++) be_tab[i] = 8'hFF;
  endtask

  initial begin
    be_all();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    checks++;
    if (req_valid !== 1'b0 || done !== 1'b0 || cmd_ready !== 1'b1)
      fail("R9", "reset state valid/done/ready", {61'b0, req_valid, done, cmd_ready}, 64'd1);

    // R3 R4 R2: 68 bytes from 0x06 -> partial, 7-qw burst, single, partial
    run(32'h06, 68, 64, 1, 0);
    // R4: aligned full segment -> one 8-qw burst
    run(32'h100, 64, 64, 1, 1);
    // R2: run hits segment end after one quadword
    run(32'h38, 32, 64, 1, 1);
    // R3 R4: byte-enable hole at quadword 3
    be_tab[3] = 8'hF0;
    run(32'h200, 64, 64, 1, 1);
    be_all();
    // R8: zero length
    run(32'h400, 0, 0, 1, 0);
    // R3: short write inside one quadword
    run(32'h1005, 3, 64, 1, 0);
    // R6 R7: long write, slow buffer, random back-pressure
    be_tab[10] = 8'h7F;
    be_tab[17] = 8'h00;
    run(32'h2010, 200, 64, 5, 1);
    be_all();
    // R6: buffer fills one quadword at a time, every 9 cycles
    run(32'h3000, 128, 64, 9, 0);
    // R1: unaligned tail ending in next segment
    run(32'h403B, 13, 64, 2, 1);
    // R8: zero length again under back-pressure mode
    run(32'h5007, 0, 0, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule